// File: doc/BRIEF.md
# Windowed Watchdog Reset Generator

This block supervises an external microcontroller. It turns a free-running `tick_i` pulse into millisecond units and counts the time since the last restart. The controller must acknowledge within a programmable timeout. If it does not, the block drives its active-low reset output for a fixed stretch. An acknowledge that comes too soon after the previous valid one is also a fault, so a runaway loop that hammers the acknowledge strobe does not keep the part alive.

The same reset output stretches and filters the power-good input. Short drops of power-good are ignored. A drop that persists holds the reset for as long as it lasts, and then for the fixed stretch after power-good returns. A sticky cause code records what produced the last reset, and a read strobe clears it. The output is only ever pulled low or released, which suits an open-drain pad outside the block. `TICKS_PER_MS` sets how many `tick_i` pulses make one millisecond; with the default of 1, every pulse is one millisecond.

Top module: `mcu_wdog`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `wdg_rst_no` is 0 and `cause_o` is 2'b11 (power). The output is released on the RST_MS-th (100th) millisecond tick after `rst_ni` rises.
- R2: The timeout is (`tmo_code_i`+1)×BASE_MS ms (32 ms per code step). With no acknowledge, `wdg_rst_no` stays 1 through the tick before the limit. It falls on the limit-th millisecond tick after the last restart, and `cause_o` becomes 2'b01 (timeout).
- R3: An acknowledge that arrives after a previous valid acknowledge with fewer than WIN_MS (2) millisecond ticks in between pulls `wdg_rst_no` low in the next cycle, and `cause_o` becomes 2'b10 (early).
- R4: An acknowledge that arrives WIN_MS or more ticks after the previous valid one is accepted and restarts the timeout count from zero.
- R5: The first acknowledge after a reset ends is always accepted, even with zero ticks elapsed.
- R6: A reset pulse lasts exactly RST_MS millisecond ticks. When it ends, the timeout count restarts from zero.
- R7: Acknowledges during a reset pulse are ignored and do not change its length.
- R8: A power-good low seen across at most FILT_MS millisecond ticks is ignored. A low seen across FILT_MS+1 ticks forces the reset and sets `cause_o` to 2'b11. The reset is held while power-good stays low and is then stretched by RST_MS ticks.
- R9: `cause_o` keeps its value until `stat_clr_i` clears it to 2'b00. A new reset event in the same cycle as the clear wins.
- R10: An acknowledge in the same cycle as the tick that would expire the timeout is accepted, and the timeout does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| pwr_good_i | input | 1 | Asynchronous power-good level, high when supply is good |
| tick_i | input | 1 | Single-cycle time-base pulse; TICKS_PER_MS pulses form 1 ms |
| ack_i | input | 1 | Single-cycle acknowledge strobe from the microcontroller |
| tmo_code_i | input | CODE_W | Timeout code n, timeout = (n+1)×BASE_MS ms |
| stat_clr_i | input | 1 | Read strobe that clears the cause code |
| cause_o | output | 2 | Last reset cause: 00 none, 01 timeout, 10 early acknowledge, 11 power |
| wdg_rst_no | output | 1 | Active-low reset; 0 means pull low, 1 means release |

## Verification
The checker assumes that `tick_i`, `ack_i` and `stat_clr_i` are single-cycle pulses. It also assumes that a reset can only start on an acknowledge, on a millisecond tick or on a filtered power failure, and can only end on a tick. The stimulus therefore drives each tick as an isolated one-cycle pulse followed by idle cycles. It changes `pwr_good_i` and `tmo_code_i` only at falling clock edges, and only in the gaps between ticks. The timeout code is held constant across each timed run. Power-good drops are placed either inside a single tick gap (a glitch) or across several ticks (a real failure), so the filter decision is unambiguous.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_TIMEOUT = 2'b01,
    CAUSE_EARLY   = 2'b10,
    CAUSE_POWER   = 2'b11
  } cause_e;
endpackage

// File: rtl/wdog_ms_tick.sv
module wdog_ms_tick #(
  parameter int TICKS_PER_MS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic ms_tick_o
);
  localparam int CNT_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_MS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap      = (cnt_q == LAST);
  assign ms_tick_o = tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_pg_filter.sv
module wdog_pg_filter #(
  parameter int FILT_MS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic ms_tick_i,
  output logic pg_fail_o
);
  localparam int LOW_MAX = FILT_MS + 1;
  localparam int LOW_W   = $clog2(LOW_MAX + 1);

  logic             pg_meta_q, pg_sync_q;
  logic [LOW_W-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_meta_q <= 1'b0;
      pg_sync_q <= 1'b0;
    end else begin
      pg_meta_q <= pwr_good_i;
      pg_sync_q <= pg_meta_q;
    end
  end

  // count ms ticks seen while supply is low; saturate at the trip level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        low_cnt_q <= '0;
    else if (pg_sync_q) low_cnt_q <= '0;
    else if (ms_tick_i && (low_cnt_q != LOW_W'(LOW_MAX)))
      low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign pg_fail_o = (low_cnt_q == LOW_W'(LOW_MAX));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int BASE_MS = 32,
  parameter int WIN_MS  = 2,
  parameter int RST_MS  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic              pg_fail_i,
  input  logic              ack_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              in_reset_o,
  output logic [1:0]        cause_o
);
  localparam int MAX_LIMIT = (2 ** CODE_W) * BASE_MS;
  localparam int WD_W      = $clog2(MAX_LIMIT + 1);
  localparam int RST_W     = $clog2(RST_MS + 1);

  logic             in_reset_q, in_reset_d;
  logic [RST_W-1:0] rst_cnt_q, rst_cnt_d;
  logic [WD_W-1:0]  wd_cnt_q, wd_cnt_d;
  logic             ack_seen_q, ack_seen_d;
  cause_e           cause_q, cause_d;

  logic [WD_W-1:0]  limit;
  logic             early, expire, rst_done;

  assign limit    = (WD_W'(code_i) + WD_W'(1)) * WD_W'(BASE_MS);
  assign early    = ack_i && ack_seen_q && (wd_cnt_q < WD_W'(WIN_MS));
  assign expire   = ms_tick_i && (({1'b0, wd_cnt_q} + (WD_W+1)'(1)) >= {1'b0, limit});
  assign rst_done = ms_tick_i && (rst_cnt_q == RST_W'(RST_MS - 1));

  always_comb begin
    in_reset_d = in_reset_q;
    rst_cnt_d  = rst_cnt_q;
    wd_cnt_d   = wd_cnt_q;
    ack_seen_d = ack_seen_q;
    cause_d    = clr_i ? CAUSE_NONE : cause_q;
    if (pg_fail_i) begin
      in_reset_d = 1'b1;
      rst_cnt_d  = '0;
      cause_d    = CAUSE_POWER;
    end else if (in_reset_q) begin
      if (rst_done) begin
        in_reset_d = 1'b0;
        rst_cnt_d  = '0;
        wd_cnt_d   = '0;
        ack_seen_d = 1'b0;
      end else if (ms_tick_i) begin
        rst_cnt_d = rst_cnt_q + 1'b1;
      end
    end else if (early) begin
      in_reset_d = 1'b1;
      rst_cnt_d  = '0;
      cause_d    = CAUSE_EARLY;
    end else if (ack_i) begin
      // ack beats a coinciding tick
      wd_cnt_d   = '0;
      ack_seen_d = 1'b1;
    end else if (expire) begin
      in_reset_d = 1'b1;
      rst_cnt_d  = '0;
      cause_d    = CAUSE_TIMEOUT;
    end else if (ms_tick_i) begin
      wd_cnt_d = wd_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_reset_q <= 1'b1;
      rst_cnt_q  <= '0;
      wd_cnt_q   <= '0;
      ack_seen_q <= 1'b0;
      cause_q    <= CAUSE_POWER;
    end else begin
      in_reset_q <= in_reset_d;
      rst_cnt_q  <= rst_cnt_d;
      wd_cnt_q   <= wd_cnt_d;
      ack_seen_q <= ack_seen_d;
      cause_q    <= cause_d;
    end
  end

  assign in_reset_o = in_reset_q;
  assign cause_o    = cause_q;
endmodule

// File: rtl/mcu_wdog.sv
module mcu_wdog #(
  parameter int TICKS_PER_MS = 1,
  parameter int CODE_W       = 4,
  parameter int BASE_MS      = 32,
  parameter int WIN_MS       = 2,
  parameter int RST_MS       = 100,
  parameter int FILT_MS      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              tick_i,
  input  logic              ack_i,
  input  logic [CODE_W-1:0] tmo_code_i,
  input  logic              stat_clr_i,
  output logic [1:0]        cause_o,
  output logic              wdg_rst_no
);
  logic ms_tick;
  logic pg_fail;
  logic in_reset;

  wdog_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ms_tick_o(ms_tick)
  );

  wdog_pg_filter #(.FILT_MS(FILT_MS)) u_pg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .ms_tick_i (ms_tick),
    .pg_fail_o (pg_fail)
  );

  wdog_ctrl #(
    .CODE_W (CODE_W),
    .BASE_MS(BASE_MS),
    .WIN_MS (WIN_MS),
    .RST_MS (RST_MS)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ms_tick_i (ms_tick),
    .pg_fail_i (pg_fail),
    .ack_i     (ack_i),
    .clr_i     (stat_clr_i),
    .code_i    (tmo_code_i),
    .in_reset_o(in_reset),
    .cause_o   (cause_o)
  );

  // drive low or release only
  assign wdg_rst_no = ~in_reset;
endmodule

// File: rtl/mcu_wdog_chk.sv
module mcu_wdog_chk #(
  parameter int RST_MS = 100
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ms_tick,
  input logic       pg_fail,
  input logic       ack_i,
  input logic       stat_clr_i,
  input logic [1:0] cause_o,
  input logic       wdg_rst_no
);
  int unsigned rcnt_q;

  // ms ticks spent in reset since the supply was last good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rcnt_q <= 0;
    else if (wdg_rst_no) rcnt_q <= 0;
    else if (pg_fail)    rcnt_q <= 0;
    else if (ms_tick)    rcnt_q <= rcnt_q + 1;
  end

  AST_RST_EXACT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdg_rst_no) |-> (rcnt_q == RST_MS)); // R6

  AST_RST_ENDS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdg_rst_no && !ms_tick) |=> !wdg_rst_no); // R7

  AST_RUN_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdg_rst_no && !pg_fail && !ack_i && !ms_tick) |=> wdg_rst_no); // R2

  AST_PWR_FAIL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_fail |=> (!wdg_rst_no && cause_o == 2'b11)); // R8

  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr_i |=> ($stable(cause_o) || $fell(wdg_rst_no) || $past(pg_fail))); // R9

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && wdg_rst_no && !pg_fail && !ack_i && !ms_tick) |=> (cause_o == 2'b00)); // R9
endmodule

bind mcu_wdog mcu_wdog_chk #(.RST_MS(RST_MS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ms_tick   (ms_tick),
  .pg_fail   (pg_fail),
  .ack_i     (ack_i),
  .stat_clr_i(stat_clr_i),
  .cause_o   (cause_o),
  .wdg_rst_no(wdg_rst_no)
);

// File: tb/mcu_wdog_test.sv
module mcu_wdog_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_good_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       ack_i = 1'b0;
  logic [3:0] tmo_code_i = 4'd0;
  logic       stat_clr_i = 1'b0;
  logic [1:0] cause_o;
  logic       wdg_rst_no;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  mcu_wdog uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .tick_i    (tick_i),
    .ack_i     (ack_i),
    .tmo_code_i(tmo_code_i),
    .stat_clr_i(stat_clr_i),
    .cause_o   (cause_o),
    .wdg_rst_no(wdg_rst_no)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rst(input string req, input string what, input int exp);
    chk(wdg_rst_no == exp[0], req, what, int'(wdg_rst_no), exp);
  endtask

  task automatic chk_cause(input string req, input int exp);
    chk(cause_o == exp[1:0], req, "cause", int'(cause_o), exp);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
      @(negedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic tick_with_ack();
    @(negedge clk_i); tick_i = 1'b1; ack_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; ack_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic ack_pulse();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk_i); stat_clr_i = 1'b1;
    @(negedge clk_i); stat_clr_i = 1'b0;
  endtask

  task automatic t_power_on();
    repeat (3) @(negedge clk_i);
    chk_rst("R1", "held in rst_ni", 0);
    chk_cause("R1", 3);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    tick_n(99);
    chk_rst("R1", "before 100th tick", 0);
    tick_n(1);
    chk_rst("R6", "after 100th tick", 1);
    chk_cause("R1", 3);
    clr_pulse();
    chk_cause("R9", 0);
  endtask

  task automatic t_timeout_min();
    tmo_code_i = 4'd0;
    tick_n(31);
    chk_rst("R2", "tick 31 of 32", 1);
    tick_n(1);
    chk_rst("R2", "tick 32 of 32", 0);
    chk_cause("R2", 1);
    tick_n(99);
    chk_rst("R6", "reset 99 ticks", 0);
    tick_n(1);
    chk_rst("R6", "reset 100 ticks", 1);
  endtask

  task automatic t_ack_restart();
    tmo_code_i = 4'd2;
    ack_pulse();
    chk_rst("R5", "first ack at zero ticks", 1);
    tick_n(50);
    ack_pulse();
    chk_rst("R4", "ack after 50 ticks", 1);
    tick_n(95);
    chk_rst("R4", "95 of 96 after restart", 1);
    tick_n(1);
    chk_rst("R2", "96 of 96", 0);
    chk_cause("R2", 1);
    clr_pulse();
    chk_cause("R9", 0);
    tick_n(100);
    chk_rst("R6", "released", 1);
  endtask

  task automatic t_early_ack();
    tmo_code_i = 4'd0;
    ack_pulse();
    tick_n(2);
    ack_pulse();
    chk_rst("R4", "ack at window edge", 1);
    tick_n(1);
    ack_pulse();
    chk_rst("R3", "ack one tick later", 0);
    chk_cause("R3", 2);
    for (int i = 0; i < 99; i++) begin
      tick_n(1);
      ack_pulse();
    end
    chk_rst("R7", "acks in reset", 0);
    tick_n(1);
    chk_rst("R7", "length unchanged", 1);
  endtask

  task automatic t_ack_at_expiry();
    tmo_code_i = 4'd0;
    ack_pulse();
    tick_n(31);
    chk_rst("R10", "before expiry", 1);
    tick_with_ack();
    chk_rst("R10", "ack with expiring tick", 1);
    tick_n(31);
    chk_rst("R10", "31 after ack", 1);
    tick_n(1);
    chk_rst("R10", "32 after ack", 0);
    tick_n(100);
    chk_rst("R6", "released", 1);
  endtask

  task automatic t_power();
    clr_pulse();
    @(negedge clk_i); pwr_good_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i); pwr_good_i = 1'b1;
    tick_n(5);
    chk_rst("R8", "glitch ignored", 1);
    chk_cause("R8", 0);
    @(negedge clk_i); pwr_good_i = 1'b0;
    tick_n(3);
    chk_rst("R8", "sustained low", 0);
    chk_cause("R8", 3);
    tick_n(150);
    chk_rst("R8", "held while low", 0);
    @(negedge clk_i); pwr_good_i = 1'b1;
    repeat (4) @(negedge clk_i);
    tick_n(99);
    chk_rst("R8", "stretch 99", 0);
    tick_n(1);
    chk_rst("R8", "stretch 100", 1);
  endtask

  task automatic t_clear_collision();
    tmo_code_i = 4'd0;
    clr_pulse();
    ack_pulse();
    tick_n(31);
    @(negedge clk_i); tick_i = 1'b1; stat_clr_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; stat_clr_i = 1'b0;
    @(negedge clk_i);
    chk_rst("R9", "timeout with clear", 0);
    chk_cause("R9", 1);
  endtask

  initial begin
    t_power_on();
    t_timeout_min();
    t_ack_restart();
    t_early_ack();
    t_ack_at_expiry();
    t_power();
    t_clear_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog R1-all: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule